// File: doc/BRIEF.md
# Weighted Consumer Load Tracker

This block keeps a weighted load figure for each load-balanced consumer and tells the scheduler whether that consumer can take more work. Each scheduled event carries a 2-bit weight code. The decoded weight is added to the target consumer's load, and the code is appended to that consumer's history FIFO. A completion for a consumer removes the oldest entry from its history and subtracts that entry's weight from the load. A consumer is available only while its load is strictly below its configured capacity.

Each consumer has a small occupancy state machine for its history list, with three states:

- `HS_EMPTY`: the history list holds no entries.
- `HS_PARTIAL`: the list holds at least one entry but is below the configured depth.
- `HS_FULL`: the list holds as many entries as the configured depth.

The transitions are:

- **fill_first** (`HS_EMPTY`→`HS_PARTIAL`): an accepted schedule.
- **drain_last** (`HS_PARTIAL`→`HS_EMPTY`): a completion that pops the last entry.
- **reach_depth** (`HS_PARTIAL`→`HS_FULL`): the entry count reaches the depth.
- **leave_full** (`HS_FULL`→`HS_PARTIAL`): a completion on a full list.
- **hold**: any cycle that leaves the entry count unchanged.

Two kinds of request are rejected and leave the load untouched:

- a schedule request to a consumer that is unavailable or whose history list is full;
- a completion that finds the history list empty.

Top module: `wclt_top`

## Requirements
- R1: After reset every load is 0, every history list is empty, `sched_err` is 0 and all `cmpl_err` bits are 0.
- R2: An accepted schedule adds the decoded weight of `sched_wcode` to the target consumer's load, and the new load is visible after the next rising edge. The decoding is 0→0, 1→2, 2→4, 3→8.
- R3: `cq_avail[i]` is 1 exactly when the load of consumer i is below its capacity field. Capacity is in the range 0 to 256, and a capacity of 0 means the consumer is never available.
- R4: A completion pops the oldest history entry of its consumer and subtracts that entry's weight from the load, so weights leave in first-in, first-out order.
- R5: The history depth limit is set per consumer by its 2-bit depth field: code 0 gives 32 entries, code 1 gives 64, and codes 2 and 3 give 128. A schedule to a consumer whose list holds that many entries is rejected.
- R6: A rejected schedule leaves the load and history unchanged. `sched_err` is 1 for exactly the one cycle after the rejected request.
- R7: A schedule and a completion to the same consumer in the same cycle produce a single update. The new load is the old load plus the new weight minus the oldest weight.
- R8: A completion to a consumer whose history list is empty leaves its load unchanged and sets that consumer's `cmpl_err` bit. The bit stays set until reset. Emptiness is judged before any schedule in the same cycle.
- R9: A request to one consumer never changes the load of another consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sched_vld | input | 1 | Schedule strobe |
| sched_cq | input | CQ_W | Consumer index of the scheduled event |
| sched_wcode | input | 2 | Weight code of the scheduled event |
| cmpl_vld | input | 1 | Completion strobe |
| cmpl_cq | input | CQ_W | Consumer index of the completion |
| cap_cfg | input | N_CQ*LOAD_W | Capacity per consumer, field i at bits [i*LOAD_W +: LOAD_W] |
| depth_cfg | input | N_CQ*2 | Depth code per consumer, field i at bits [i*2 +: 2] |
| cq_avail | output | N_CQ | Availability per consumer |
| cq_load | output | N_CQ*LOAD_W | Load per consumer, same field layout as `cap_cfg` |
| sched_err | output | 1 | One-cycle pulse after a rejected schedule |
| cmpl_err | output | N_CQ | Sticky flag per consumer for a completion on an empty history |

## Verification
The assertions assume that `cap_cfg` and `depth_cfg` stay constant while traffic runs and that capacities never exceed 256. They also assume the strobes are low during reset. The bench writes all configuration before releasing reset and never changes it afterwards. It drives every strobe on the falling edge and clears it one time step after the rising edge, so each request is seen at exactly one edge.

// File: rtl/wclt_pkg.sv
package wclt_pkg;

    // Occupancy of one consumer's history list
    typedef enum logic [1:0] {
        HS_EMPTY   = 2'd0,
        HS_PARTIAL = 2'd1,
        HS_FULL    = 2'd2
    } hist_state_e;

    // 2-bit weight code to weight value
    function automatic logic [3:0] weight_of(input logic [1:0] code);
        logic [3:0] w;
        unique case (code)
            2'd0:    w = 4'd0;
            2'd1:    w = 4'd2;
            2'd2:    w = 4'd4;
            default: w = 4'd8;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cq_hist_fifo.sv
module cq_hist_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [DW-1:0]               push_data,
    input  logic                        pop,
    output logic [DW-1:0]               head_data,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_data = mem[rd_ptr];
    assign count     = cnt_q;

    // R5: the owner never pushes into a list with no free slot
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt_q < DEPTH_C));

    // R4: the owner never pops a list that holds nothing
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/cq_load_slot.sv
module cq_load_slot
    import wclt_pkg::*;
#(
    parameter int MAX_DEPTH = 128,
    parameter int LOAD_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_hit,
    input  logic [1:0]        sched_code,
    input  logic              cmpl_hit,
    input  logic [LOAD_W-1:0] cap,
    input  logic [1:0]        depth_code,
    output logic              avail,
    output logic [LOAD_W-1:0] load,
    output logic              rejected,
    output logic              cmpl_err
);
    localparam int CNT_W = $clog2(MAX_DEPTH+1);
    localparam int LIM0  = (MAX_DEPTH < 32)  ? MAX_DEPTH : 32;
    localparam int LIM1  = (MAX_DEPTH < 64)  ? MAX_DEPTH : 64;
    localparam int LIM2  = (MAX_DEPTH < 128) ? MAX_DEPTH : 128;

    hist_state_e       state_q, state_d;
    logic [LOAD_W-1:0] load_q, load_d;
    logic              cmpl_err_q;
    logic [CNT_W-1:0]  count, count_d, lim;
    logic [1:0]        head_code;
    logic [3:0]        w_add, w_sub;
    logic              hist_empty, hist_full;
    logic              accept, pop_do;

    cq_hist_fifo #(
        .DEPTH (MAX_DEPTH),
        .DW    (2)
    ) i_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (sched_code),
        .pop       (pop_do),
        .head_data (head_code),
        .count     (count)
    );

    // Depth limit selected by the configuration code
    always_comb begin
        unique case (depth_code)
            2'd0:    lim = CNT_W'(LIM0);
            2'd1:    lim = CNT_W'(LIM1);
            default: lim = CNT_W'(LIM2);
        endcase
    end

    // Output decode from the occupancy state
    always_comb begin
        hist_empty = 1'b0;
        hist_full  = 1'b0;
        unique case (state_q)
            HS_EMPTY:   hist_empty = 1'b1;
            HS_PARTIAL: ;
            HS_FULL:    hist_full  = 1'b1;
            default:    hist_empty = 1'b1;
        endcase
    end

    assign avail    = (load_q < cap);
    assign accept   = sched_hit && avail && !hist_full;
    assign pop_do   = cmpl_hit && !hist_empty;
    assign rejected = sched_hit && !accept;
    assign w_add    = weight_of(sched_code);
    assign w_sub    = weight_of(head_code);

    // Next load and next occupancy
    always_comb begin
        load_d  = load_q;
        if (accept) load_d = load_d + LOAD_W'(w_add);
        if (pop_do) load_d = load_d - LOAD_W'(w_sub);
        count_d = count + CNT_W'(accept) - CNT_W'(pop_do);
        if (count_d == '0) begin
            state_d = HS_EMPTY;
        end else if (count_d >= lim) begin
            state_d = HS_FULL;
        end else begin
            state_d = HS_PARTIAL;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= HS_EMPTY;
            load_q     <= '0;
            cmpl_err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            load_q  <= load_d;
            if (cmpl_hit && hist_empty) begin
                cmpl_err_q <= 1'b1;
            end
        end
    end

    assign load     = load_q;
    assign cmpl_err = cmpl_err_q;

    // R2: an accepted schedule alone grows the load by its weight
    a_r2_add_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pop_do) |=> (load_q == $past(load_q) + LOAD_W'($past(w_add))));

    // R4: a completion alone shrinks the load by the oldest weight
    a_r4_sub_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_do && !accept) |=> (load_q == $past(load_q) - LOAD_W'($past(w_sub))));

    // R7: both in one cycle give the net change
    a_r7_net_update: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_do && accept) |=> (load_q == $past(load_q) + LOAD_W'($past(w_add)) - LOAD_W'($past(w_sub))));

    // R3: a consumer at or over capacity never takes an event
    a_r3_cap_block: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_hit && (load_q >= cap)) |-> !accept);

    // R6: a rejected schedule with no completion leaves the load alone
    a_r6_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rejected && !cmpl_hit) |=> $stable(load_q));

    // R8: the empty-completion flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_err_q |=> cmpl_err_q);

    // R9: no request for this consumer, no change in its load
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_hit && !cmpl_hit) |=> $stable(load_q));

endmodule

// File: rtl/wclt_top.sv
module wclt_top #(
    parameter int N_CQ      = 4,
    parameter int MAX_DEPTH = 128,
    parameter int LOAD_W    = 9,
    localparam int CQ_W     = (N_CQ > 1) ? $clog2(N_CQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sched_vld,
    input  logic [CQ_W-1:0]          sched_cq,
    input  logic [1:0]               sched_wcode,
    input  logic                     cmpl_vld,
    input  logic [CQ_W-1:0]          cmpl_cq,
    input  logic [N_CQ*LOAD_W-1:0]   cap_cfg,
    input  logic [N_CQ*2-1:0]        depth_cfg,
    output logic [N_CQ-1:0]          cq_avail,
    output logic [N_CQ*LOAD_W-1:0]   cq_load,
    output logic                     sched_err,
    output logic [N_CQ-1:0]          cmpl_err
);
    logic [N_CQ-1:0] rej_vec;
    logic            sched_err_q;

    for (genvar i = 0; i < N_CQ; i++) begin : g_cq
        logic s_hit, c_hit;
        assign s_hit = sched_vld && (sched_cq == CQ_W'(i));
        assign c_hit = cmpl_vld  && (cmpl_cq  == CQ_W'(i));

        cq_load_slot #(
            .MAX_DEPTH (MAX_DEPTH),
            .LOAD_W    (LOAD_W)
        ) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sched_hit  (s_hit),
            .sched_code (sched_wcode),
            .cmpl_hit   (c_hit),
            .cap        (cap_cfg[i*LOAD_W +: LOAD_W]),
            .depth_code (depth_cfg[i*2 +: 2]),
            .avail      (cq_avail[i]),
            .load       (cq_load[i*LOAD_W +: LOAD_W]),
            .rejected   (rej_vec[i]),
            .cmpl_err   (cmpl_err[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sched_err_q <= 1'b0;
        end else begin
            sched_err_q <= |rej_vec;
        end
    end

    assign sched_err = sched_err_q;

    // R6: a request to an unavailable consumer raises the error pulse
    a_r6_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_vld && !cq_avail[sched_cq]) |=> sched_err);

    // R6: the pulse needs a schedule request in the previous cycle
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_vld |=> !sched_err);

endmodule

// File: tb/test_wclt_top.sv
module test_wclt_top;
    localparam int N_CQ   = 4;
    localparam int LOAD_W = 9;
    localparam int CQ_W   = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   sched_vld = 1'b0;
    logic [CQ_W-1:0]        sched_cq = '0;
    logic [1:0]             sched_wcode = '0;
    logic                   cmpl_vld = 1'b0;
    logic [CQ_W-1:0]        cmpl_cq = '0;
    logic [N_CQ*LOAD_W-1:0] cap_cfg;
    logic [N_CQ*2-1:0]      depth_cfg;
    logic [N_CQ-1:0]        cq_avail;
    logic [N_CQ*LOAD_W-1:0] cq_load;
    logic                   sched_err;
    logic [N_CQ-1:0]        cmpl_err;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    wclt_top #(.N_CQ(N_CQ), .MAX_DEPTH(128), .LOAD_W(LOAD_W)) i_wclt_top (
        .clk(clk), .rst_n(rst_n),
        .sched_vld(sched_vld), .sched_cq(sched_cq), .sched_wcode(sched_wcode),
        .cmpl_vld(cmpl_vld), .cmpl_cq(cmpl_cq),
        .cap_cfg(cap_cfg), .depth_cfg(depth_cfg),
        .cq_avail(cq_avail), .cq_load(cq_load),
        .sched_err(sched_err), .cmpl_err(cmpl_err)
    );

    function automatic int load_of(input int i);
        return int'(cq_load[i*LOAD_W +: LOAD_W]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; results are sampled 1 time unit after the edge
    task automatic step(input bit sv, input int scq, input int code,
                        input bit cv, input int ccq);
        @(negedge clk);
        sched_vld   = sv;
        sched_cq    = CQ_W'(scq);
        sched_wcode = 2'(code);
        cmpl_vld    = cv;
        cmpl_cq     = CQ_W'(ccq);
        @(posedge clk);
        #1;
        sched_vld = 1'b0;
        cmpl_vld  = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 load0", load_of(0), 0);
        chk("R1 load2", load_of(2), 0);
        chk("R1 avail", int'(cq_avail), 4'b0111);
        chk("R1 sched_err", int'(sched_err), 0);
        chk("R1 cmpl_err", int'(cmpl_err), 0);
    endtask

    task automatic t_weights;
        step(1, 0, 0, 0, 0); chk("R2 code0", load_of(0), 0);
        step(1, 0, 1, 0, 0); chk("R2 code1", load_of(0), 2);
        step(1, 0, 2, 0, 0); chk("R2 code2", load_of(0), 6);
        step(1, 0, 3, 0, 0); chk("R2 code3", load_of(0), 14);
    endtask

    task automatic t_fifo_order;
        step(0, 0, 0, 1, 0); chk("R4 pop w0", load_of(0), 14);
        step(0, 0, 0, 1, 0); chk("R4 pop w2", load_of(0), 12);
        step(0, 0, 0, 1, 0); chk("R4 pop w4", load_of(0), 8);
        step(0, 0, 0, 1, 0); chk("R4 pop w8", load_of(0), 0);
    endtask

    task automatic t_capacity;
        step(1, 1, 3, 0, 0);
        chk("R3 below cap load", load_of(1), 8);
        chk("R3 below cap avail", int'(cq_avail[1]), 1);
        step(1, 1, 1, 0, 0);
        chk("R3 at cap load", load_of(1), 10);
        chk("R3 at cap avail", int'(cq_avail[1]), 0);
        step(1, 1, 0, 0, 0);
        chk("R6 reject load", load_of(1), 10);
        chk("R6 reject err", int'(sched_err), 1);
        step(0, 0, 0, 0, 0);
        chk("R6 err one cycle", int'(sched_err), 0);
        step(0, 0, 0, 1, 1);
        chk("R6 reject left history", load_of(1), 2);
        chk("R3 avail again", int'(cq_avail[1]), 1);
        step(1, 3, 1, 0, 0);
        chk("R3 cap zero load", load_of(3), 0);
        chk("R3 cap zero err", int'(sched_err), 1);
    endtask

    task automatic t_empty_cmpl;
        step(0, 0, 0, 1, 2);
        chk("R8 load kept", load_of(2), 0);
        chk("R8 flag", int'(cmpl_err), 4'b0100);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R8 sticky", int'(cmpl_err), 4'b0100);
    endtask

    task automatic t_same_cycle;
        step(1, 0, 2, 0, 0);
        step(1, 0, 1, 0, 0);
        chk("R7 pre", load_of(0), 6);
        step(1, 0, 3, 1, 0);
        chk("R7 net", load_of(0), 10);
        step(0, 0, 0, 1, 0); chk("R7 order a", load_of(0), 8);
        step(0, 0, 0, 1, 0); chk("R7 order b", load_of(0), 0);
        chk("R8 no new flag", int'(cmpl_err), 4'b0100);
    endtask

    task automatic t_depth;
        for (int k = 0; k < 32; k++) step(1, 2, 1, 0, 0);
        chk("R5 filled load", load_of(2), 64);
        chk("R5 still avail", int'(cq_avail[2]), 1);
        step(1, 2, 1, 0, 0);
        chk("R5 full reject load", load_of(2), 64);
        chk("R5 full reject err", int'(sched_err), 1);
        step(0, 0, 0, 1, 2);
        chk("R5 after pop", load_of(2), 62);
        step(1, 2, 1, 0, 0);
        chk("R5 accept again", load_of(2), 64);
        chk("R5 no err", int'(sched_err), 0);
    endtask

    task automatic t_isolation;
        chk("R9 cq0 untouched", load_of(0), 0);
        chk("R9 cq1 untouched", load_of(1), 2);
        chk("R9 cq3 untouched", load_of(3), 0);
    endtask

    initial begin
        cap_cfg   = '0;
        depth_cfg = '0;
        cap_cfg[0*LOAD_W +: LOAD_W] = 9'd256;
        cap_cfg[1*LOAD_W +: LOAD_W] = 9'd10;
        cap_cfg[2*LOAD_W +: LOAD_W] = 9'd256;
        cap_cfg[3*LOAD_W +: LOAD_W] = 9'd0;
        depth_cfg[0*2 +: 2] = 2'd2;
        depth_cfg[1*2 +: 2] = 2'd1;
        depth_cfg[2*2 +: 2] = 2'd0;
        depth_cfg[3*2 +: 2] = 2'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_weights;
        t_fifo_order;
        t_capacity;
        t_empty_cmpl;
        t_same_cycle;
        t_depth;
        t_isolation;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule